// File: doc/BRIEF.md
# Shared Interrupt Source Router

The router takes a parameterised number of level-sensitive interrupt sources and steers each one to one interrupt pin of one processor. Every source keeps four pieces of state. A pending bit records the last level seen on its input. An enable bit gates it. A pin map holds a pin number and a map-to-pin flag. A target map names the processor that receives it, or marks the source as unmapped. The router has one output for each (processor, pin) pair. That output is high while any enabled, pending source routed to that pair is pending. Each processor also supplies a local compare term, which is ORed onto whichever of its pins it selects.

Software reaches the state through a word-wide register port with combinational read data. Pending and enable state is read as bitmaps of eight sources per word. Enables change only through two write-1 bitmaps, one that sets and one that clears. A single edge register lets software force the pending level of any source. Routing words are held one per source: a pin word with a 4-byte stride and a target word with a 16-byte stride. The target word is written and read as a one-hot processor vector.

Top module: `irq_src_router`

## Requirements
- R1: After reset, every output is low. The pending and enable bitmaps read 0. Each pin-map word reads 0x8000_0000 (flag bit 31 set, pin 0). Each target-map word reads 0 (unmapped).
- R2: A source's pending bit takes the new input level on the clock edge after any input transition, whether or not the source is enabled. It then holds that level until the next transition or edge-register write.
- R3: A source whose enable bit is clear drives no output, whatever its pending bit and routing.
- R4: A write to the set bitmap (byte offset 0x200 + 4g) enables each source whose data bit is 1. A write to the clear bitmap (0x300 + 4g) disables each source whose data bit is 1. Zero bits leave enables unchanged. The enable bitmap reads back at 0x100 + 4g.
- R5: Bitmap group g at offsets 0x000 (pending) and 0x100 (enable) covers sources 8g..8g+7, with source 8g+i in data bit i (bits 31:8 read 0). A group with 8g+8 greater than the source count reads 0, and writes to it change nothing.
- R6: The target word of source s sits at 0x2000 + 16s. A nonzero write stores the index of its lowest set bit, and a write of 0 marks the source unmapped. A write whose index is not below the processor count is discarded. Reads return a word with only the mapped processor's bit set, or 0 when the source is unmapped.
- R7: The pin word of source s sits at 0x1000 + 4s. Bits 5:0 hold the pin number and bit 31 the map-to-pin flag. Other written bits are dropped. A write whose pin number exceeds the highest pin is discarded. Words of sources at or past the source count read 0.
- R8: A write to the edge register at 0x400 sets the pending bit of the source indexed by data bits 30:0 to data bit 31. An index at or past the source count changes nothing.
- R9: Output p*PINS + n is the OR of every enabled, pending source mapped to processor p and pin n, together with processor p's local term. The local term counts when its pending and unmask inputs are both high and its pin input equals n.
- R10: When an edge-register write and an input transition reach the same source on the same clock edge, the edge-register level is stored.
- R11: A source output follows the state change of the clock edge that registered the input transition or write, with no further delay. The local term reaches the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Level-sensitive interrupt sources, synchronous to clk |
| local_pend | input | NUM_PROC | Local compare pending bit of each processor |
| local_en | input | NUM_PROC | Local compare unmask bit of each processor |
| local_pin | input | NUM_PROC*PIN_FLD_W | Pin chosen by each processor's local term |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 14 | Register byte address, word aligned |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_out | output | NUM_PROC*NUM_PIN | Interrupt lines, index proc*NUM_PIN + pin |

## Verification
Two things can update a pending bit on the same clock edge: a hardware transition on the source input and a software edge-register write that names the same source. The bench provokes this by changing the input and presenting the write in one low clock phase, so that a single rising edge captures both. It then judges the result from the pending bitmap. The edge-register level must win, and the bit must stay there while the input holds still. A second case forces a level by software while the input is idle, to show that the priority does not simply mask the write path.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int REG_W        = 32;
   localparam int ADDR_W       = 14;
   localparam int PIN_FLAG_BIT = 31;
   localparam int EDGE_LVL_BIT = 31;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_PEND,
      RG_MASK,
      RG_SET,
      RG_CLR,
      RG_EDGE,
      RG_PINMAP,
      RG_TGTMAP
   } rgn_e;

   // Word-aligned address decode into register regions.
   function automatic rgn_e region_of(input logic [ADDR_W-1:0] a);
      rgn_e r;
      r = RG_NONE;
      if (a[1:0] == 2'b00) begin
         case (a[13:12])
            2'd0: begin
               case (a[11:8])
                  4'd0: r = RG_PEND;
                  4'd1: r = RG_MASK;
                  4'd2: r = RG_SET;
                  4'd3: r = RG_CLR;
                  4'd4: if (a[7:2] == 6'd0) r = RG_EDGE;
                  default: r = RG_NONE;
               endcase
            end
            2'd1: r = RG_PINMAP;
            2'd2: if (a[3:2] == 2'b00) r = RG_TGTMAP;
            default: r = RG_NONE;
         endcase
      end
      return r;
   endfunction

   // Index of the lowest set bit; 0 for an all-zero word.
   function automatic logic [4:0] lowest_set(input logic [REG_W-1:0] d);
      logic [4:0] r;
      r = '0;
      for (int i = REG_W - 1; i >= 0; i--) begin
         if (d[i]) r = 5'(i);
      end
      return r;
   endfunction

endpackage

// File: rtl/irq_router_decode.sv
module irq_router_decode
   import irq_router_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int NUM_PROC  = 2,
   parameter int NUM_PIN   = 6,
   parameter int PIN_FLD_W = 6,
   localparam int PROC_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [REG_W-1:0]      reg_wdata,
   output logic [NUM_SRC-1:0]    set_hit,
   output logic [NUM_SRC-1:0]    clr_hit,
   output logic [NUM_SRC-1:0]    edge_hit,
   output logic [NUM_SRC-1:0]    pin_we,
   output logic [NUM_SRC-1:0]    tgt_we,
   output logic                  edge_lvl,
   output logic [PIN_FLD_W-1:0]  pin_val,
   output logic                  pin_flag,
   output logic                  tgt_map,
   output logic [PROC_W-1:0]     tgt_idx
);

   rgn_e        rgn;
   logic [5:0]  grp;
   logic [9:0]  pin_src;
   logic [7:0]  tgt_src;
   logic [4:0]  low_idx;
   logic        pin_ok;
   logic        tgt_ok;

   assign rgn     = region_of(reg_addr);
   assign grp     = reg_addr[7:2];
   assign pin_src = reg_addr[11:2];
   assign tgt_src = reg_addr[11:4];

   // Pin word: number in low field, flag on top, range checked.
   assign pin_val  = reg_wdata[PIN_FLD_W-1:0];
   assign pin_flag = reg_wdata[PIN_FLAG_BIT];
   assign pin_ok   = int'(pin_val) <= (NUM_PIN - 1);

   // Target word: one-hot in, lowest set bit wins, zero means unmapped.
   assign low_idx  = lowest_set(reg_wdata);
   assign tgt_map  = |reg_wdata;
   assign tgt_ok   = !tgt_map || (int'(low_idx) < NUM_PROC);
   assign tgt_idx  = PROC_W'(low_idx);

   assign edge_lvl = reg_wdata[EDGE_LVL_BIT];

   // Groups and indices past NUM_SRC match no source, so they fall away.
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam logic [5:0] GRP_OF = 6'(s / 8);
      localparam int         BIT_OF = s % 8;

      assign set_hit[s]  = reg_wr && (rgn == RG_SET) && (grp == GRP_OF)
                           && reg_wdata[BIT_OF];
      assign clr_hit[s]  = reg_wr && (rgn == RG_CLR) && (grp == GRP_OF)
                           && reg_wdata[BIT_OF];
      assign edge_hit[s] = reg_wr && (rgn == RG_EDGE)
                           && (reg_wdata[EDGE_LVL_BIT-1:0] == 31'(s));
      assign pin_we[s]   = reg_wr && (rgn == RG_PINMAP)
                           && (pin_src == 10'(s)) && pin_ok;
      assign tgt_we[s]   = reg_wr && (rgn == RG_TGTMAP)
                           && (tgt_src == 8'(s)) && tgt_ok;
   end

endmodule

// File: rtl/irq_router_srcbank.sv
module irq_router_srcbank #(
   parameter int NUM_SRC   = 32,
   parameter int NUM_PROC  = 2,
   parameter int NUM_PIN   = 6,
   parameter int PIN_FLD_W = 6,
   localparam int PROC_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_SRC-1:0]                 src_in,
   input  logic [NUM_SRC-1:0]                 set_hit,
   input  logic [NUM_SRC-1:0]                 clr_hit,
   input  logic [NUM_SRC-1:0]                 edge_hit,
   input  logic [NUM_SRC-1:0]                 pin_we,
   input  logic [NUM_SRC-1:0]                 tgt_we,
   input  logic                               edge_lvl,
   input  logic [PIN_FLD_W-1:0]               pin_val,
   input  logic                               pin_flag,
   input  logic                               tgt_map,
   input  logic [PROC_W-1:0]                  tgt_idx,
   output logic [NUM_SRC-1:0]                 pend_q,
   output logic [NUM_SRC-1:0]                 en_q,
   output logic [NUM_SRC-1:0][PIN_FLD_W-1:0]  pin_q,
   output logic [NUM_SRC-1:0]                 flag_q,
   output logic [NUM_SRC-1:0]                 tmap_q,
   output logic [NUM_SRC-1:0][PROC_W-1:0]     tidx_q
);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic                 prev_r;
      logic                 pend_r;
      logic                 en_r;
      logic [PIN_FLD_W-1:0] pin_r;
      logic                 flag_r;
      logic                 tmap_r;
      logic [PROC_W-1:0]    tidx_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_r <= 1'b0;
            pend_r <= 1'b0;
            en_r   <= 1'b0;
            pin_r  <= '0;
            flag_r <= 1'b1;
            tmap_r <= 1'b0;
            tidx_r <= '0;
         end else begin
            prev_r <= src_in[s];
            // Software level beats a same-edge input transition.
            if (edge_hit[s]) begin
               pend_r <= edge_lvl;
            end else if (src_in[s] != prev_r) begin
               pend_r <= src_in[s];
            end
            if (set_hit[s]) begin
               en_r <= 1'b1;
            end else if (clr_hit[s]) begin
               en_r <= 1'b0;
            end
            if (pin_we[s]) begin
               pin_r  <= pin_val;
               flag_r <= pin_flag;
            end
            if (tgt_we[s]) begin
               tmap_r <= tgt_map;
               tidx_r <= tgt_map ? tgt_idx : '0;
            end
         end
      end

      assign pend_q[s] = pend_r;
      assign en_q[s]   = en_r;
      assign pin_q[s]  = pin_r;
      assign flag_q[s] = flag_r;
      assign tmap_q[s] = tmap_r;
      assign tidx_q[s] = tidx_r;

      // R2
      pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!edge_hit[s] && (src_in[s] != prev_r)) |=> (pend_r == $past(src_in[s])));

      // R10
      edge_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
         edge_hit[s] |=> (pend_r == $past(edge_lvl)));

      // R4
      set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_hit[s] |=> en_r);

      // R4
      clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_hit[s] && !set_hit[s]) |=> !en_r);

      // R6
      tgt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tmap_r |-> (int'(tidx_r) < NUM_PROC));

      // R7
      pin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         int'(pin_r) <= (NUM_PIN - 1));
   end

endmodule

// File: rtl/irq_router_fanin.sv
module irq_router_fanin #(
   parameter int NUM_SRC   = 32,
   parameter int NUM_PROC  = 2,
   parameter int NUM_PIN   = 6,
   parameter int PIN_FLD_W = 6,
   localparam int PROC_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
   localparam int NUM_OUT  = NUM_PROC * NUM_PIN
) (
   input  logic [NUM_SRC-1:0]                  pend_q,
   input  logic [NUM_SRC-1:0]                  en_q,
   input  logic [NUM_SRC-1:0][PIN_FLD_W-1:0]   pin_q,
   input  logic [NUM_SRC-1:0]                  tmap_q,
   input  logic [NUM_SRC-1:0][PROC_W-1:0]      tidx_q,
   input  logic [NUM_PROC-1:0]                 local_pend,
   input  logic [NUM_PROC-1:0]                 local_en,
   input  logic [NUM_PROC-1:0][PIN_FLD_W-1:0]  local_pin,
   output logic [NUM_OUT-1:0]                  irq_out
);

   logic [NUM_SRC-1:0] live;
   assign live = pend_q & en_q & tmap_q;

   for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
      for (genvar n = 0; n < NUM_PIN; n++) begin : g_pin
         logic hit;
         always_comb begin
            hit = local_pend[p] && local_en[p]
                  && (local_pin[p] == PIN_FLD_W'(n));
            for (int s = 0; s < NUM_SRC; s++) begin
               if (live[s] && (tidx_q[s] == PROC_W'(p))
                   && (pin_q[s] == PIN_FLD_W'(n))) begin
                  hit = 1'b1;
               end
            end
         end
         assign irq_out[p*NUM_PIN + n] = hit;
      end
   end

endmodule

// File: rtl/irq_router_readback.sv
module irq_router_readback
   import irq_router_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int NUM_PROC  = 2,
   parameter int PIN_FLD_W = 6,
   localparam int PROC_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
   localparam int NUM_GRP  = NUM_SRC / 8
) (
   input  logic [ADDR_W-1:0]                  reg_addr,
   input  logic [NUM_SRC-1:0]                 pend_q,
   input  logic [NUM_SRC-1:0]                 en_q,
   input  logic [NUM_SRC-1:0][PIN_FLD_W-1:0]  pin_q,
   input  logic [NUM_SRC-1:0]                 flag_q,
   input  logic [NUM_SRC-1:0]                 tmap_q,
   input  logic [NUM_SRC-1:0][PROC_W-1:0]     tidx_q,
   output logic [REG_W-1:0]                   reg_rdata
);

   rgn_e       rgn;
   logic [5:0] grp;
   logic [9:0] pin_src;
   logic [7:0] tgt_src;

   assign rgn     = region_of(reg_addr);
   assign grp     = reg_addr[7:2];
   assign pin_src = reg_addr[11:2];
   assign tgt_src = reg_addr[11:4];

   always_comb begin
      reg_rdata = '0;
      case (rgn)
         RG_PEND: begin
            for (int g = 0; g < NUM_GRP; g++) begin
               if (grp == 6'(g)) reg_rdata[7:0] = pend_q[g*8 +: 8];
            end
         end
         RG_MASK: begin
            for (int g = 0; g < NUM_GRP; g++) begin
               if (grp == 6'(g)) reg_rdata[7:0] = en_q[g*8 +: 8];
            end
         end
         RG_PINMAP: begin
            for (int s = 0; s < NUM_SRC; s++) begin
               if (pin_src == 10'(s)) begin
                  reg_rdata[PIN_FLD_W-1:0]  = pin_q[s];
                  reg_rdata[PIN_FLAG_BIT]   = flag_q[s];
               end
            end
         end
         RG_TGTMAP: begin
            for (int s = 0; s < NUM_SRC; s++) begin
               if ((tgt_src == 8'(s)) && tmap_q[s]) begin
                  reg_rdata = REG_W'(1) << tidx_q[s];
               end
            end
         end
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
   import irq_router_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int NUM_PROC  = 2,
   parameter int NUM_PIN   = 6,
   parameter int PIN_FLD_W = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             src_in,
   input  logic [NUM_PROC-1:0]            local_pend,
   input  logic [NUM_PROC-1:0]            local_en,
   input  logic [NUM_PROC*PIN_FLD_W-1:0]  local_pin,
   input  logic                           reg_wr,
   input  logic [ADDR_W-1:0]              reg_addr,
   input  logic [REG_W-1:0]               reg_wdata,
   output logic [REG_W-1:0]               reg_rdata,
   output logic [NUM_PROC*NUM_PIN-1:0]    irq_out
);

   localparam int PROC_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1;

   if ((NUM_SRC % 8 != 0) || (NUM_SRC < 8) || (NUM_SRC > 256)) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 8 between 8 and 256");
   end
   if ((NUM_PROC < 1) || (NUM_PROC > REG_W)) begin : g_bad_proc
      $error("NUM_PROC must lie between 1 and the register width");
   end
   if ((NUM_PIN < 1) || (NUM_PIN > (1 << PIN_FLD_W)) || (PIN_FLD_W > 30)) begin : g_bad_pin
      $error("NUM_PIN must fit the pin field");
   end

   logic [NUM_SRC-1:0]                 set_hit, clr_hit, edge_hit, pin_we, tgt_we;
   logic                               edge_lvl, pin_flag, tgt_map;
   logic [PIN_FLD_W-1:0]               pin_val;
   logic [PROC_W-1:0]                  tgt_idx;
   logic [NUM_SRC-1:0]                 pend_q, en_q, flag_q, tmap_q;
   logic [NUM_SRC-1:0][PIN_FLD_W-1:0]  pin_q;
   logic [NUM_SRC-1:0][PROC_W-1:0]     tidx_q;
   logic [NUM_PROC-1:0][PIN_FLD_W-1:0] local_pin_a;

   assign local_pin_a = local_pin;

   irq_router_decode #(
      .NUM_SRC(NUM_SRC), .NUM_PROC(NUM_PROC), .NUM_PIN(NUM_PIN), .PIN_FLD_W(PIN_FLD_W)
   ) u_dec (
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .set_hit(set_hit), .clr_hit(clr_hit), .edge_hit(edge_hit),
      .pin_we(pin_we), .tgt_we(tgt_we), .edge_lvl(edge_lvl),
      .pin_val(pin_val), .pin_flag(pin_flag), .tgt_map(tgt_map), .tgt_idx(tgt_idx)
   );

   irq_router_srcbank #(
      .NUM_SRC(NUM_SRC), .NUM_PROC(NUM_PROC), .NUM_PIN(NUM_PIN), .PIN_FLD_W(PIN_FLD_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .set_hit(set_hit), .clr_hit(clr_hit), .edge_hit(edge_hit),
      .pin_we(pin_we), .tgt_we(tgt_we), .edge_lvl(edge_lvl),
      .pin_val(pin_val), .pin_flag(pin_flag), .tgt_map(tgt_map), .tgt_idx(tgt_idx),
      .pend_q(pend_q), .en_q(en_q), .pin_q(pin_q), .flag_q(flag_q),
      .tmap_q(tmap_q), .tidx_q(tidx_q)
   );

   irq_router_fanin #(
      .NUM_SRC(NUM_SRC), .NUM_PROC(NUM_PROC), .NUM_PIN(NUM_PIN), .PIN_FLD_W(PIN_FLD_W)
   ) u_fan (
      .pend_q(pend_q), .en_q(en_q), .pin_q(pin_q), .tmap_q(tmap_q), .tidx_q(tidx_q),
      .local_pend(local_pend), .local_en(local_en), .local_pin(local_pin_a),
      .irq_out(irq_out)
   );

   irq_router_readback #(
      .NUM_SRC(NUM_SRC), .NUM_PROC(NUM_PROC), .PIN_FLD_W(PIN_FLD_W)
   ) u_rd (
      .reg_addr(reg_addr), .pend_q(pend_q), .en_q(en_q), .pin_q(pin_q),
      .flag_q(flag_q), .tmap_q(tmap_q), .tidx_q(tidx_q), .reg_rdata(reg_rdata)
   );

   // R3
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & en_q) == '0 && (local_pend & local_en) == '0) |-> (irq_out == '0));

   // R9
   out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out != '0) |-> (((pend_q & en_q & tmap_q) != '0) || ((local_pend & local_en) != '0)));

endmodule

// File: tb/sim_irq_src_router.sv
module sim_irq_src_router;

   localparam int NUM_SRC = 32;
   localparam int NUM_PROC = 2;
   localparam int NUM_PIN = 6;
   localparam int PF = 6;
   localparam int NV = 31;

   logic                        clk = 1'b0;
   logic                        rst_n = 1'b0;
   logic [NUM_SRC-1:0]          src_in = '0;
   logic [NUM_PROC-1:0]         local_pend = '0;
   logic [NUM_PROC-1:0]         local_en = '0;
   logic [NUM_PROC*PF-1:0]      local_pin = '0;
   logic                        reg_wr = 1'b0;
   logic [13:0]                 reg_addr = '0;
   logic [31:0]                 reg_wdata = '0;
   logic [31:0]                 reg_rdata;
   logic [NUM_PROC*NUM_PIN-1:0] irq_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   irq_src_router #(.NUM_SRC(NUM_SRC), .NUM_PROC(NUM_PROC), .NUM_PIN(NUM_PIN), .PIN_FLD_W(PF)) u0 (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .local_pend(local_pend),
      .local_en(local_en), .local_pin(local_pin), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   // Entry: {req number, is_read, address, write data or expected read}
   localparam logic [50:0] VEC [0:NV-1] = '{
      {4'd1, 1'b1, 14'h0000, 32'h0000_0000},  // R1 pending clear
      {4'd1, 1'b1, 14'h0100, 32'h0000_0000},  // R1 enables clear
      {4'd1, 1'b1, 14'h1000, 32'h8000_0000},  // R1 pin word default
      {4'd1, 1'b1, 14'h2000, 32'h0000_0000},  // R1 unmapped
      {4'd4, 1'b0, 14'h0200, 32'h0000_00A5},  // R4 set 0,2,5,7
      {4'd4, 1'b1, 14'h0100, 32'h0000_00A5},
      {4'd4, 1'b0, 14'h0300, 32'h0000_0021},  // R4 clear 0,5
      {4'd4, 1'b1, 14'h0100, 32'h0000_0084},
      {4'd5, 1'b0, 14'h0204, 32'h0000_00FF},  // R5 group 1
      {4'd5, 1'b1, 14'h0104, 32'h0000_00FF},
      {4'd5, 1'b0, 14'h0210, 32'h0000_00FF},  // R5 group past the end
      {4'd5, 1'b1, 14'h0110, 32'h0000_0000},
      {4'd6, 1'b0, 14'h2010, 32'h0000_0006},  // R6 lowest bit 1
      {4'd6, 1'b1, 14'h2010, 32'h0000_0002},
      {4'd6, 1'b0, 14'h2010, 32'h0000_0004},  // R6 index 2 rejected
      {4'd6, 1'b1, 14'h2010, 32'h0000_0002},
      {4'd6, 1'b0, 14'h2010, 32'h0000_0000},  // R6 unmap
      {4'd6, 1'b1, 14'h2010, 32'h0000_0000},
      {4'd7, 1'b0, 14'h1008, 32'hFFFF_FFC3},  // R7 stray bits dropped
      {4'd7, 1'b1, 14'h1008, 32'h8000_0003},
      {4'd7, 1'b0, 14'h1008, 32'h0000_0006},  // R7 pin 6 rejected
      {4'd7, 1'b1, 14'h1008, 32'h8000_0003},
      {4'd7, 1'b0, 14'h1008, 32'h0000_0005},
      {4'd7, 1'b1, 14'h1008, 32'h0000_0005},
      {4'd8, 1'b0, 14'h0400, 32'h8000_0003},  // R8 raise source 3
      {4'd8, 1'b1, 14'h0000, 32'h0000_0008},
      {4'd8, 1'b0, 14'h0400, 32'h8000_0020},  // R8 index 32 ignored
      {4'd8, 1'b1, 14'h0000, 32'h0000_0008},
      {4'd8, 1'b0, 14'h0400, 32'h0000_0003},  // R8 lower source 3
      {4'd8, 1'b1, 14'h0000, 32'h0000_0000},
      {4'd7, 1'b1, 14'h1080, 32'h0000_0000}   // R7 source 32 reads 0
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic do_read(input logic [13:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 outputs in reset", 32'(irq_out), 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][46]) do_read(VEC[i][45:32], VEC[i][31:0], $sformatf("R%0d vec %0d", VEC[i][50:47], i));
         else            do_write(VEC[i][45:32], VEC[i][31:0]);
      end

      // R9 / R11: source 2 (pin 5, enabled) to processor 1
      do_write(14'h2020, 32'h2);
      @(negedge clk);
      src_in[2] = 1'b1;
      #1 check("R11 no output before edge", 32'(irq_out), 32'h0);
      @(negedge clk);
      check("R9 R11 src2 on proc1 pin5", 32'(irq_out), 32'h800);
      do_read(14'h0000, 32'h04, "R2 pending src2");
      // R3: disable source 2, pending stays
      do_write(14'h0300, 32'h04);
      check("R3 disabled source silent", 32'(irq_out), 32'h0);
      do_read(14'h0000, 32'h04, "R2 pending kept while disabled");
      do_read(14'h0100, 32'h80, "R4 clear left bit 7");

      // R2 / R3: never-enabled source 4
      @(negedge clk);
      src_in[4] = 1'b1;
      @(negedge clk);
      do_read(14'h0000, 32'h14, "R2 disabled source latches level");
      check("R3 source 4 silent", 32'(irq_out), 32'h0);

      // R9 / R11: local term, combinational
      @(negedge clk);
      local_pend[0] = 1'b1; local_en[0] = 1'b1; local_pin[PF-1:0] = 6'd2;
      #1 check("R9 R11 local term proc0 pin2", 32'(irq_out), 32'h004);
      local_en[0] = 1'b0;
      #1 check("R9 masked local term", 32'(irq_out), 32'h0);
      local_pend[0] = 1'b0;

      // R9: two sources OR onto proc0 pin1; R6 lowest bit
      do_write(14'h1020, 32'h1);
      do_write(14'h1024, 32'h1);
      do_write(14'h2080, 32'h1);
      do_write(14'h2090, 32'h3);
      do_read(14'h2090, 32'h1, "R6 lowest set bit of 0x3");
      do_write(14'h0400, 32'h8000_0008);
      check("R9 src8 drives proc0 pin1", 32'(irq_out), 32'h002);
      do_write(14'h0400, 32'h8000_0009);
      do_write(14'h0400, 32'h0000_0008);
      check("R9 src9 alone keeps pin1", 32'(irq_out), 32'h002);
      do_write(14'h0400, 32'h0000_0009);
      check("R9 both low", 32'(irq_out), 32'h0);

      // R10: same-edge input rise and software lower on source 10
      @(negedge clk);
      src_in[10] = 1'b1;
      reg_wr = 1'b1; reg_addr = 14'h0400; reg_wdata = 32'h0000_000A;
      @(negedge clk);
      reg_wr = 1'b0;
      do_read(14'h0004, 32'h00, "R10 edge register wins");
      @(negedge clk);
      do_read(14'h0004, 32'h00, "R10 level holds while input steady");
      do_write(14'h0400, 32'h8000_000B);
      do_read(14'h0004, 32'h08, "R10 forced level with idle input");
      check("R9 unmapped src11 silent", 32'(irq_out), 32'h0);

      // R1: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1 check("R1 outputs after reset", 32'(irq_out), 32'h0);
      do_read(14'h0100, 32'h0, "R1 enables after reset");
      do_read(14'h1008, 32'h8000_0000, "R1 pin word after reset");
      do_read(14'h2080, 32'h0, "R1 target after reset");
      do_read(14'h0000, 32'h0, "R1 pending after reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(14'h0000, 32'h14, "R2 held inputs after reset g0");
      do_read(14'h0004, 32'h04, "R2 held inputs after reset g1");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule